// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances at the instruction rate, which is the system clock divided by four. That rate first goes through a selectable prescaler. The counter climbs from zero until it equals a software-programmed period value. On the next advance it returns to zero and emits a one-cycle match pulse.

The match pulse leaves the block on `baud_tick`, ahead of any postscaling, so a serial port can use it as its shift-clock source. The same pulse also feeds a programmable postscaler. The postscaler's terminal pulse sets a sticky interrupt flag. An interrupt request is raised while the flag and its enable are both set.

Software reaches the block through a small register bus. A write is taken on the rising clock edge when `bus_we` is high. A read is combinational from `bus_addr`. The bus has no handshake and never stalls: every access completes in the cycle it is presented, so no back-pressure rule applies.

Top module: `pm_timer`

## Requirements
- R1: After reset the registers read as follows: control at address 0 reads 00h, count at address 1 reads 00h, period at address 2 reads FFh, interrupt register at address 3 reads 04h. `baud_tick` and `irq` are low.
- R2: Control register (address 0) layout: bits 6:3 hold the postscaler select, bit 2 is the run enable, and bits 1:0 hold the prescaler select. Bit 7 always reads 0, so writing FFh reads back 7Fh.
- R3: With the timer running, the count goes from 0 up to the period value. The advance taken while the count equals the period returns it to 0 and raises `baud_tick` for that one cycle. With a 1:1 prescale, consecutive pulses are 4*(period+1) clocks apart.
- R4: Prescaler select values: 00 gives 1:1, 01 gives 1:4, and both 10 and 11 give 1:16. With period 1, the `baud_tick` spacing is 8, 32 and 128 clocks respectively.
- R5: With postscaler select S, the interrupt flag is set by every (S+1)-th match pulse, counted from the last control or count write.
- R6: The interrupt flag (address 3 bit 0) stays set until software writes 0 to it. If a hardware set and a software clear fall in the same cycle, the set wins.
- R7: Interrupt register layout: bit 0 is the flag, bit 1 is the enable, and bit 2 is the priority bit. `irq` is high exactly when both the flag and the enable are 1.
- R8: Any write to the control or count register clears the prescaler and postscaler progress. A control write leaves the count value unchanged.
- R9: While the run enable is 0, the count holds its value and `baud_tick` stays low.
- R10: If the period is set below the current count, the count keeps climbing through FFh, wraps to 00h, and then matches the period normally.
- R11: A write to the count register (address 1) loads the written value and takes precedence over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 period, 3 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| baud_tick | output | 1 | One-cycle match pulse, taken before the postscaler |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
Two events can fall in the same clock edge: the postscaler's terminal pulse setting the flag, and a software write clearing that flag. The bench sets the postscaler to 1:1 and waits until it sees `baud_tick` high. In that same cycle it issues the clear write, so both events land on one edge, and it then checks that the flag reads back as 1. A second clear, issued away from any match, must read back as 0. This confirms the clear path itself works and that only the set priority kept the flag alive.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_COUNT  = 2'd1,
    ADDR_PERIOD = 2'd2,
    ADDR_IRQ    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] post_sel;
    logic       run;
    logic [1:0] pre_sel;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int PRE_CW   = 4;
  localparam int POST_SW  = 4;
endpackage

// File: rtl/pm_timer_clkdiv.sv
module pm_timer_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);
endmodule

// File: rtl/pm_timer_prescale.sv
module pm_timer_prescale
  import pm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_CW-1:0] pcnt_q;
  logic [PRE_CW-1:0] limit;

  always_comb begin
    case (sel)
      2'b00:   limit = PRE_CW'(0);
      2'b01:   limit = PRE_CW'(3);
      default: limit = PRE_CW'(15);
    endcase
  end

  assign tick = step && (pcnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (clr)  pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else if (step) pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_timer_core.sv
module pm_timer_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;

  assign match = step && (cnt_q == period);
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (match) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_timer_postscale.sv
module pm_timer_postscale
  import pm_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [POST_SW-1:0] sel,
  output logic               term
);
  logic [POST_SW-1:0] mcnt_q;

  assign term = step && (mcnt_q == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mcnt_q <= '0;
    else if (clr)  mcnt_q <= '0;
    else if (term) mcnt_q <= '0;
    else if (step) mcnt_q <= mcnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             baud_tick,
  output logic             irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, ien_q, prio_q;
  logic             inst_tick, pre_tick, post_term, timer_on;
  logic             wr_ctrl, wr_count, wr_period, wr_irq, seq_clr;

  assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
  assign wr_count  = bus_we && (bus_addr == ADDR_COUNT);
  assign wr_period = bus_we && (bus_addr == ADDR_PERIOD);
  assign wr_irq    = bus_we && (bus_addr == ADDR_IRQ);
  assign seq_clr   = wr_ctrl || wr_count;
  assign timer_on  = ctrl_q.run;

  pm_timer_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk (clk), .rst_n (rst_n), .tick (inst_tick)
  );

  pm_timer_prescale u_pre (
    .clk (clk), .rst_n (rst_n), .clr (seq_clr),
    .step (inst_tick && timer_on), .sel (ctrl_q.pre_sel), .tick (pre_tick)
  );

  pm_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk (clk), .rst_n (rst_n), .step (pre_tick), .load (wr_count),
    .load_val (bus_wdata), .period (period_q), .cnt (cnt_q), .match (baud_tick)
  );

  pm_timer_postscale u_post (
    .clk (clk), .rst_n (rst_n), .clr (seq_clr),
    .step (baud_tick), .sel (ctrl_q.post_sel), .term (post_term)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_period) period_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      prio_q <= 1'b1;
    end else begin
      if (post_term)   flag_q <= 1'b1;
      else if (wr_irq) flag_q <= bus_wdata[0];
      if (wr_irq) begin
        ien_q  <= bus_wdata[1];
        prio_q <= bus_wdata[2];
      end
    end
  end

  assign irq = flag_q && ien_q;

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:   bus_rdata = CNT_W'(ctrl_q);
      ADDR_COUNT:  bus_rdata = cnt_q;
      ADDR_PERIOD: bus_rdata = period_q;
      default:     bus_rdata = CNT_W'({prio_q, ien_q, flag_q});
    endcase
  end
endmodule

// File: rtl/pm_timer_chk.sv
module pm_timer_chk
  import pm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_rdata,
  input logic             baud_tick,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             timer_on,
  input logic             flag,
  input logic             post_term
);
  assert_match_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !(bus_we && bus_addr == ADDR_COUNT)) |=> (cnt == '0));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_on |-> !baud_tick);

  assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_on && !bus_we) |=> $stable(cnt));

  assert_post_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    post_term |-> baud_tick);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    post_term |=> flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_we && bus_addr == ADDR_IRQ)) |=> flag);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_ctrl_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTRL) |-> !bus_rdata[7]);
endmodule

bind pm_timer pm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
  .bus_rdata (bus_rdata), .baud_tick (baud_tick), .irq (irq),
  .cnt (cnt_q), .timer_on (timer_on), .flag (flag_q), .post_term (post_term)
);

// File: tb/pm_timer_bench.sv
`timescale 1ns/1ps
module pm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       baud_tick, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pm_timer u_pm_timer (
    .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .baud_tick (baud_tick), .irq (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 5000);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
    rd(2'd1, v); check(v == 8'h00, "R1 count", v, 8'h00);
    rd(2'd2, v); check(v == 8'hFF, "R1 period", v, 8'hFF);
    rd(2'd3, v); check(v == 8'h04, "R1 irq reg", v, 8'h04);
    check(!baud_tick && !irq, "R1 outputs", {baud_tick, irq}, 0);
  endtask

  task automatic t_ctrl_fields;
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check(v == 8'h7F, "R2 bit7 reads 0", v, 8'h7F);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_period;
    int n;
    logic [7:0] v;
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h04);
    wait_tick(n);
    wait_tick(n); check(n == 16, "R3 interval period 3", n, 16);
    @(negedge clk);
    rd(2'd1, v); check(v == 8'h00, "R3 count back to 0", v, 0);
  endtask

  task automatic t_prescale;
    int n;
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h04);
    wait_tick(n); wait_tick(n); check(n == 8, "R4 prescale 1:1", n, 8);
    wr(2'd0, 8'h05);
    wait_tick(n); wait_tick(n); check(n == 32, "R4 prescale 1:4", n, 32);
    wr(2'd0, 8'h06);
    wait_tick(n); wait_tick(n); check(n == 128, "R4 prescale 1:16 (10)", n, 128);
    wr(2'd0, 8'h07);
    wait_tick(n); wait_tick(n); check(n == 128, "R4 prescale 1:16 (11)", n, 128);
  endtask

  task automatic t_postscale;
    int n;
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd1);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h14);
    n = 0;
    bus_addr = 2'd3;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (bus_rdata[0]) break;
      if (baud_tick) n++;
    end
    check(n == 3, "R5 postscale 1:3 matches before flag", n, 3);
    check(!irq, "R7 irq low while disabled", irq, 0);
    wr(2'd3, 8'h03);
    #1; check(irq, "R7 irq high with flag and enable", irq, 1);
    wr(2'd0, 8'h00);
    repeat (50) @(negedge clk);
    rd(2'd3, v); check(v[0], "R6 flag sticky", v[0], 1);
    wr(2'd3, 8'h02);
    rd(2'd3, v); check(!v[0] && !irq, "R6 R7 software clear", {v[0], irq}, 0);
  endtask

  task automatic t_collision;
    int n;
    logic [7:0] v;
    wr(2'd3, 8'h00);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h04);
    wait_tick(n);
    @(negedge clk);
    rd(2'd3, v); check(v[0], "R6 flag set by match", v[0], 1);
    wait_tick(n);
    wr(2'd3, 8'h00);
    rd(2'd3, v); check(v[0], "R6 set wins over same-cycle clear", v[0], 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); check(!v[0], "R6 clear away from match", v[0], 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_clear_on_write;
    int n;
    logic [7:0] c, v;
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h06);
    wait_tick(n);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h06);
    wait_tick(n);
    check(n >= 56 && n <= 66, "R8 prescaler restarts on ctrl write", n, 62);
    wr(2'd2, 8'hC8);
    wr(2'd0, 8'h04);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd1, c);
    wr(2'd0, 8'h06);
    rd(2'd1, v); check(v == c && c != 0, "R8 ctrl write keeps count", v, c);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] c, v;
    bit seen;
    seen = 0;
    rd(2'd1, c);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (baud_tick) seen = 1;
    end
    check(!seen, "R9 no pulse while off", seen, 0);
    rd(2'd1, v); check(v == c, "R9 count holds while off", v, c);
  endtask

  task automatic t_count_write;
    logic [7:0] v;
    wr(2'd1, 8'h55);
    rd(2'd1, v); check(v == 8'h55, "R11 load while off", v, 8'h55);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h04);
    repeat (9) @(negedge clk);
    wr(2'd1, 8'h20);
    rd(2'd1, v); check(v == 8'h20, "R11 load while running", v, 8'h20);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_wrap;
    int n;
    logic [7:0] v;
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h04);
    wait_tick(n);
    check(n >= 576 && n <= 582, "R10 wrap through FFh before match", n, 578);
    rd(2'd1, v); check(v == 8'h10, "R10 match at period after wrap", v, 8'h10);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_period();
    t_prescale();
    t_postscale();
    t_collision();
    t_clear_on_write();
    t_hold();
    t_count_write();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule